// File: doc/BRIEF.md
# Deferred Invalidation Queue with Load Fence

This block sits between the coherence bus and one core's private cache. Incoming invalidate requests are answered at once, in the same cycle they are presented. The invalidation itself is recorded in a small in-order queue and handed to the cache later, one entry per cycle, whenever the cache's tag port has a free slot. This keeps the remote writer from stalling while it waits for the local tag update.

While a line address sits in the queue, the core must not send any coherence traffic of its own for that line. A lookup port compares a line address against every held entry in a single cycle and raises a blocked flag on a hit. A load-fence input holds back later loads until everything queued up to that point, plus anything that arrives while the fence is waiting, has been handed to the cache.

Top module: `inv_defer_queue`

## Requirements
- R1: After reset the queue is empty: `inv_valid`, `load_stall` and `look_blocked` are low, and `req_ack` is low while `req_valid` is low.
- R2: When fewer than DEPTH entries are held, `req_ack` is high in the same cycle that `req_valid` is high, and the request is taken at that clock edge.
- R3: An accepted request does not reach the cache in its own cycle. It shows on `inv_valid`/`inv_addr` from the next cycle onward.
- R4: Entries leave in arrival order, one per clock edge at which `inv_valid` and `cache_ready` are both high. While `cache_ready` is low, the head entry stays on `inv_addr` unchanged.
- R5: When DEPTH entries are held at the start of a cycle, `req_ack` is low and the request is not taken, even if an entry leaves in that cycle. It is acknowledged in a later cycle once room exists.
- R6: `look_blocked` is high in the same cycle exactly when `look_addr` equals the address of a held entry. It drops in the cycle after that entry leaves.
- R7: A `fence_req` pulse raises `load_stall` from the next cycle. `load_stall` stays high while any entry is held or a request is presented.
- R8: `load_stall` falls in the cycle after a cycle in which it was high, the queue was empty, `req_valid` was low and `fence_req` was low. A fence on an idle, empty queue therefore stalls for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Invalidate request from the bus |
| req_addr | input | ADDR_W | Line address to invalidate |
| req_ack | output | 1 | Immediate acknowledge; low means the queue is full |
| inv_valid | output | 1 | A queued invalidation is offered to the cache |
| inv_addr | output | ADDR_W | Line address of the offered invalidation |
| cache_ready | input | 1 | Cache tag port free; takes the offered entry |
| look_addr | input | ADDR_W | Line address the core wants to use |
| look_blocked | output | 1 | That line still has a pending invalidation |
| fence_req | input | 1 | Load-fence issue pulse |
| load_stall | output | 1 | Hold subsequent loads |

## Verification
`req_ack` and `look_blocked` are combinational, so they are checked mid-cycle in the same cycle as the stimulus. The queue head appears one edge after acceptance, and the fence stall rises one edge after its pulse and falls one edge after the first empty, quiet cycle. The bench drives inputs just after each rising edge and samples on the falling edge, so it can count the edges between stimulus and result. A scoreboard holds the accepted addresses in order. A monitor pops and compares them at every cycle in which the cache takes an entry, and drain lengths and stall edges are counted cycle by cycle.

// File: rtl/invq_pkg.sv
package invq_pkg;

    typedef enum logic {
        FN_OPEN = 1'b0,
        FN_HOLD = 1'b1
    } fence_e;

endpackage

// File: rtl/invq_store.sv
module invq_store #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  logic [ADDR_W-1:0]                push_addr,
    input  logic                             pop,
    output logic                             full,
    output logic                             empty,
    output logic [ADDR_W-1:0]                head_addr,
    output logic [DEPTH-1:0][ADDR_W-1:0]     slot_addr,
    output logic [DEPTH-1:0]                 slot_vld
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0]             vld;
        logic [PTR_W-1:0]             head;
        logic [PTR_W-1:0]             tail;
        logic [CNT_W-1:0]             count;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.addr[st_q.tail] = push_addr;
            st_d.vld[st_q.tail]  = 1'b1;
            st_d.tail            = ptr_next(st_q.tail);
        end
        if (pop) begin
            st_d.vld[st_q.head] = 1'b0;
            st_d.head           = ptr_next(st_q.head);
        end
        st_d.count = st_q.count + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full      = (st_q.count == CNT_W'(DEPTH));
    assign empty     = (st_q.count == '0);
    assign head_addr = st_q.addr[st_q.head];
    assign slot_addr = st_q.addr;
    assign slot_vld  = st_q.vld;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.count < CNT_W'(DEPTH))); // R5
    AST_POP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.count != '0)); // R4
    AST_VLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.vld) == int'(st_q.count)); // R4
    AST_GROW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (st_q.count == $past(st_q.count) + 1'b1)); // R2

endmodule

// File: rtl/invq_match.sv
module invq_match #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            look_addr,
    input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    input  logic [DEPTH-1:0]             slot_vld,
    output logic                         blocked
);

    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = slot_vld[g] && (slot_addr[g] == look_addr);
    end

    assign blocked = |hit;

    AST_BLOCK_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> (slot_vld != '0)); // R6

endmodule

// File: rtl/invq_fence.sv
module invq_fence
    import invq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fence_req,
    input  logic drained,
    input  logic req_seen,
    output logic stall
);

    typedef struct packed {
        fence_e mode;
    } fence_t;

    fence_t fn_d, fn_q;

    always_comb begin
        fn_d = fn_q;
        if (fence_req)
            fn_d.mode = FN_HOLD;
        else if (fn_q.mode == FN_HOLD && drained && !req_seen)
            fn_d.mode = FN_OPEN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fn_q <= '{mode: FN_OPEN};
        else        fn_q <= fn_d;
    end

    assign stall = (fn_q.mode == FN_HOLD);

    AST_STALL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        fence_req |=> stall); // R7
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && (!drained || req_seen)) |=> stall); // R7

endmodule

// File: rtl/inv_defer_queue.sv
module inv_defer_queue #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ack,
    output logic              inv_valid,
    output logic [ADDR_W-1:0] inv_addr,
    input  logic              cache_ready,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_blocked,
    input  logic              fence_req,
    output logic              load_stall
);

    logic                         q_full;
    logic                         q_empty;
    logic                         q_pop;
    logic [DEPTH-1:0][ADDR_W-1:0] q_slot_addr;
    logic [DEPTH-1:0]             q_slot_vld;

    assign req_ack   = req_valid && !q_full;
    assign inv_valid = !q_empty;
    assign q_pop     = inv_valid && cache_ready;

    invq_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (req_ack),
        .push_addr (req_addr),
        .pop       (q_pop),
        .full      (q_full),
        .empty     (q_empty),
        .head_addr (inv_addr),
        .slot_addr (q_slot_addr),
        .slot_vld  (q_slot_vld)
    );

    invq_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_addr (look_addr),
        .slot_addr (q_slot_addr),
        .slot_vld  (q_slot_vld),
        .blocked   (look_blocked)
    );

    invq_fence u_fence (
        .clk       (clk),
        .rst_n     (rst_n),
        .fence_req (fence_req),
        .drained   (q_empty),
        .req_seen  (req_valid),
        .stall     (load_stall)
    );

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !cache_ready) |=> (inv_valid && $stable(inv_addr))); // R4
    AST_BLOCK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        look_blocked |-> inv_valid); // R6
    AST_ACK_NEXT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> inv_valid); // R3

endmodule

// File: tb/inv_defer_queue_tb_top.sv
module inv_defer_queue_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          req_ack;
    logic          inv_valid;
    logic [AW-1:0] inv_addr;
    logic          cache_ready;
    logic [AW-1:0] look_addr;
    logic          look_blocked;
    logic          fence_req;
    logic          load_stall;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [AW-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    inv_defer_queue #(.ADDR_W(AW), .DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ack(req_ack), .inv_valid(inv_valid), .inv_addr(inv_addr),
        .cache_ready(cache_ready), .look_addr(look_addr),
        .look_blocked(look_blocked), .fence_req(fence_req), .load_stall(load_stall)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Driver: present one request, wait for acceptance, record expected item.
    task automatic send(input logic [AW-1:0] a);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        while (!req_ack) begin
            tick();
            @(negedge clk);
        end
        exp_q.push_back(a);
        tick();
        req_valid = 1'b0;
    endtask

    // Monitor: compare every entry the cache takes against the scoreboard.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && inv_valid && cache_ready) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected pop", 32'(inv_addr), 32'hFFFF_FFFF);
            end else begin
                logic [AW-1:0] e;
                e = exp_q.pop_front();
                chk("R4 order", 32'(inv_addr), 32'(e));
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        int n;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; cache_ready = 1'b0;
        look_addr = '0; fence_req = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 inv_valid", 32'(inv_valid), 0);
        chk("R1 load_stall", 32'(load_stall), 0);
        chk("R1 look_blocked", 32'(look_blocked), 0);
        chk("R1 req_ack", 32'(req_ack), 0);

        // Immediate ack, deferred presentation
        tick();
        req_valid = 1'b1; req_addr = 16'h0100; look_addr = 16'h0100;
        @(negedge clk);
        chk("R2 same-cycle ack", 32'(req_ack), 1);
        chk("R3 not yet offered", 32'(inv_valid), 0);
        chk("R6 not blocked before accept", 32'(look_blocked), 0);
        exp_q.push_back(16'h0100);
        tick();
        req_valid = 1'b0;
        @(negedge clk);
        chk("R3 offered next cycle", 32'(inv_valid), 1);
        chk("R3 offered address", 32'(inv_addr), 32'h0100);
        chk("R6 blocked on held line", 32'(look_blocked), 1);

        // Fill to DEPTH, backpressure
        tick();
        send(16'h0101);
        send(16'h0102);
        send(16'h0103);
        req_valid = 1'b1; req_addr = 16'h0104; look_addr = 16'h0104;
        @(negedge clk);
        chk("R5 ack withheld when full", 32'(req_ack), 0);
        chk("R6 absent line not blocked", 32'(look_blocked), 0);
        chk("R4 head held while not ready", 32'(inv_addr), 32'h0100);
        tick();
        cache_ready = 1'b1;
        @(negedge clk);
        chk("R5 no ack in pop cycle", 32'(req_ack), 0);
        tick();
        send(16'h0104);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!inv_valid) break;
            n++;
            tick();
        end
        chk("R4 drain one per cycle", 32'(n), 3);
        chk("R4 scoreboard empty", 32'(exp_q.size()), 0);
        look_addr = 16'h0100;
        #1;
        chk("R6 cleared after leave", 32'(look_blocked), 0);

        // Fence with held entries
        tick();
        cache_ready = 1'b0;
        send(16'h0200);
        send(16'h0201);
        fence_req = 1'b1;
        tick();
        fence_req = 1'b0;
        @(negedge clk);
        chk("R7 stall rises", 32'(load_stall), 1);
        tick();
        @(negedge clk);
        chk("R7 stall holds while queued", 32'(load_stall), 1);
        tick();
        cache_ready = 1'b1;
        tick();
        tick();
        @(negedge clk);
        chk("R8 queue empty", 32'(inv_valid), 0);
        chk("R8 stall one more cycle", 32'(load_stall), 1);
        tick();
        @(negedge clk);
        chk("R8 stall released", 32'(load_stall), 0);

        // Fence on empty queue
        tick();
        fence_req = 1'b1;
        tick();
        fence_req = 1'b0;
        @(negedge clk);
        chk("R8 empty fence stalls", 32'(load_stall), 1);
        tick();
        @(negedge clk);
        chk("R8 empty fence one cycle", 32'(load_stall), 0);

        // Request arriving during fence keeps stall
        tick();
        fence_req = 1'b1;
        tick();
        fence_req = 1'b0;
        send(16'h0300);
        @(negedge clk);
        chk("R7 stall with arrival", 32'(load_stall), 1);
        chk("R3 arrival offered", 32'(inv_valid), 1);
        tick();
        @(negedge clk);
        chk("R7 stall after last pop", 32'(load_stall), 1);
        tick();
        @(negedge clk);
        chk("R8 stall released after arrival", 32'(load_stall), 0);

        // Back-to-back streaming with simultaneous push and pop
        tick();
        send(16'h0400);
        send(16'h0401);
        send(16'h0402);
        send(16'h0403);
        send(16'h0404);
        repeat (8) tick();
        @(negedge clk);
        chk("R4 stream drained in order", 32'(exp_q.size()), 0);
        chk("R4 stream queue empty", 32'(inv_valid), 0);

        tick();
        finish_run();
    end

endmodule